// File: doc/BRIEF.md
# Physical Address Region Router

This block sits between the processor's physical memory bus and the targets behind it. Each accepted request is looked up in a region map and steered to exactly one destination: system RAM or one of several device ports. Software programs a small set of device windows, each a base and limit pair with an owning device and a priority given by its index. Two fixed holes are never served by RAM. The first is the legacy range from 640 KB up to 1 MB. The second is the device hole from a programmable base up to the 4 GB line. An address inside either hole that no enabled window claims completes with an error.

A programmable reclaim window sits above the 4 GB line. Requests that land in it are translated and sent to RAM, onto the memory that lies behind the device hole. The translation subtracts the reclaim base and adds the hole base.

The router holds one request at a time. It decodes the request when it accepts it, keeps the chosen route fixed until the target acknowledges, and returns a one-cycle response. The region configuration is written through a small select/data port. A write is taken only while no request is in flight, so a request that has already been decoded is never rerouted.

Top module: `phys_region_router`

## Requirements
- R1: After reset the router is idle: `req_ready` is 1 and no target valid or `rsp_valid` is set. All windows are disabled, the hole base is 0xC000_0000, and the reclaim window is empty.
- R2: An address that hits no enabled window, no hole and no reclaim window goes to RAM at its own address.
- R3: An address inside several enabled windows goes to the device of the lowest-numbered window. The device port receives the untranslated address.
- R4: An address in 0x000A_0000..0x000F_FFFF is never sent to RAM. It goes to a claiming window's device, or it fails with an error.
- R5: An address in [hole base, 0xFFFF_FFFF] that no enabled window claims fails with an error.
- R6: An address in [reclaim base, reclaim limit] that no window or hole takes goes to RAM at address − reclaim base + hole base.
- R7: A failing request raises no target valid. One cycle after acceptance it returns `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata` all ones. Failing writes are discarded.
- R8: While a request is held, `req_ready` is 0 and at most one target valid is high. That valid, and the address, write flag and write data, stay stable until the target's ready.
- R9: The cycle after a target's ready, `rsp_valid`=1 and `rsp_err`=0, and `rsp_rdata` carries that target's read data.
- R10: A configuration write issued while a request is held is dropped.
- R11: Configuration select codes: 0 is the hole base, 1 is the reclaim base, 2 is the reclaim limit. Window i uses 4(i+1) for base, 4(i+1)+1 for the inclusive limit, and 4(i+1)+2 for control (bit 0 enable, bits 4:1 device index). A disabled window never matches. An enabled window whose device index is N_DEV or above fails with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Router idle, request taken on this edge |
| req_addr | input | 36 | Physical address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion |
| rsp_err | output | 1 | Request fell into an unowned hole |
| rsp_rdata | output | DATA_W | Read data (all ones on error) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration register select |
| cfg_wdata | input | 36 | Configuration write value |
| ram_valid | output | 1 | Request to RAM |
| ram_ready | input | 1 | RAM completes |
| ram_addr | output | 36 | RAM address (translated when reclaimed) |
| ram_we | output | 1 | RAM write flag |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data |
| dev_valid | output | N_DEV | Per-device request |
| dev_ready | input | N_DEV | Per-device completion |
| dev_addr | output | 36 | Device address (untranslated) |
| dev_we | output | 1 | Device write flag |
| dev_wdata | output | DATA_W | Device write data |
| dev_rdata | input | N_DEV*DATA_W | Device read data, device j at bits j*DATA_W |

## Verification
Several rules are watched on every cycle: that only one target is driven at a time, that a held route and its payload do not change before the acknowledge, that no new request is taken while one is held, that an acknowledged RAM read comes back the next cycle, and that an error response never followed a target request. Routing itself can only be shown by the bench's scenarios. These cover window priority, the two holes, reclaim translation at its edges, dropped configuration writes and disabled windows, with each result compared against a reference map kept in the bench.

// File: rtl/parr_pkg.sv
package parr_pkg;

    localparam int PA_W     = 36;
    localparam int DEVIDX_W = 4;

    typedef logic [PA_W-1:0] paddr_t;

    localparam paddr_t LEGACY_LO      = 36'h0_000A_0000;
    localparam paddr_t LEGACY_HI      = 36'h0_000F_FFFF;
    localparam paddr_t BELOW_4G_TOP   = 36'h0_FFFF_FFFF;
    localparam paddr_t HOLE_BASE_RST  = 36'h0_C000_0000;

    // configuration select codes for the global registers
    localparam int SEL_HOLE_BASE = 0;
    localparam int SEL_RCL_BASE  = 1;
    localparam int SEL_RCL_LIM   = 2;
    // window i occupies codes 4*(i+1) + field
    localparam int FLD_BASE  = 0;
    localparam int FLD_LIMIT = 1;
    localparam int FLD_CTRL  = 2;

    typedef enum logic [1:0] {
        DST_RAM  = 2'd0,
        DST_DEV  = 2'd1,
        DST_NONE = 2'd2
    } dst_kind_e;

    typedef struct packed {
        dst_kind_e             kind;
        logic [DEVIDX_W-1:0]   dev;
        paddr_t                addr;
    } route_t;

    typedef struct packed {
        logic                  en;
        logic [DEVIDX_W-1:0]   dev;
        paddr_t                base;
        paddr_t                limit;
    } window_t;

    function automatic logic in_span(paddr_t a, paddr_t lo, paddr_t hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic int win_sel(int idx, int fld);
        return 4 * (idx + 1) + fld;
    endfunction

endpackage

// File: rtl/parr_cfg.sv
module parr_cfg
    import parr_pkg::*;
#(
    parameter int N_REGION = 4,
    parameter int SEL_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  paddr_t           wr_data,
    output window_t          win [N_REGION],
    output paddr_t           hole_base,
    output paddr_t           rcl_base,
    output paddr_t           rcl_lim
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hole_base <= HOLE_BASE_RST;
            rcl_base  <= '1;
            rcl_lim   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_W'(SEL_HOLE_BASE)) hole_base <= wr_data;
            if (wr_sel == SEL_W'(SEL_RCL_BASE))  rcl_base  <= wr_data;
            if (wr_sel == SEL_W'(SEL_RCL_LIM))   rcl_lim   <= wr_data;
        end
    end

    for (genvar i = 0; i < N_REGION; i++) begin : g_win
        localparam int S_BASE  = win_sel(i, FLD_BASE);
        localparam int S_LIMIT = win_sel(i, FLD_LIMIT);
        localparam int S_CTRL  = win_sel(i, FLD_CTRL);

        always_ff @(posedge clk) begin
            if (rst) begin
                win[i] <= '0;
            end else if (wr_en) begin
                if (wr_sel == SEL_W'(S_BASE))  win[i].base  <= wr_data;
                if (wr_sel == SEL_W'(S_LIMIT)) win[i].limit <= wr_data;
                if (wr_sel == SEL_W'(S_CTRL)) begin
                    win[i].en  <= wr_data[0];
                    win[i].dev <= wr_data[DEVIDX_W:1];
                end
            end
        end
    end

endmodule

// File: rtl/parr_decode.sv
module parr_decode
    import parr_pkg::*;
#(
    parameter int N_REGION = 4,
    parameter int N_DEV    = 3
) (
    input  paddr_t  addr,
    input  window_t win [N_REGION],
    input  paddr_t  hole_base,
    input  paddr_t  rcl_base,
    input  paddr_t  rcl_lim,
    output route_t  route
);

    logic [N_REGION-1:0] hit;

    for (genvar i = 0; i < N_REGION; i++) begin : g_hit
        assign hit[i] = win[i].en && in_span(addr, win[i].base, win[i].limit);
    end

    logic                found;
    logic [DEVIDX_W-1:0] pick;

    // lowest index wins: scan upward and keep the first hit
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N_REGION; i++) begin
            if (!found && hit[i]) begin
                found = 1'b1;
                pick  = win[i].dev;
            end
        end
    end

    always_comb begin
        route.kind = DST_RAM;
        route.dev  = '0;
        route.addr = addr;
        if (found) begin
            if (int'(pick) < N_DEV) begin
                route.kind = DST_DEV;
                route.dev  = pick;
            end else begin
                route.kind = DST_NONE;
            end
        end else if (in_span(addr, LEGACY_LO, LEGACY_HI)) begin
            route.kind = DST_NONE;
        end else if (in_span(addr, hole_base, BELOW_4G_TOP)) begin
            route.kind = DST_NONE;
        end else if (in_span(addr, rcl_base, rcl_lim)) begin
            route.addr = addr - rcl_base + hole_base;
        end
    end

endmodule

// File: rtl/phys_region_router.sv
module phys_region_router
    import parr_pkg::*;
#(
    parameter int N_REGION = 4,
    parameter int N_DEV    = 3,
    parameter int DATA_W   = 32,
    parameter int SEL_W    = $clog2(4 * (N_REGION + 1))
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [PA_W-1:0]         req_addr,
    input  logic                    req_we,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [DATA_W-1:0]       rsp_rdata,
    input  logic                    cfg_we,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [PA_W-1:0]         cfg_wdata,
    output logic                    ram_valid,
    input  logic                    ram_ready,
    output logic [PA_W-1:0]         ram_addr,
    output logic                    ram_we,
    output logic [DATA_W-1:0]       ram_wdata,
    input  logic [DATA_W-1:0]       ram_rdata,
    output logic [N_DEV-1:0]        dev_valid,
    input  logic [N_DEV-1:0]        dev_ready,
    output logic [PA_W-1:0]         dev_addr,
    output logic                    dev_we,
    output logic [DATA_W-1:0]       dev_wdata,
    input  logic [N_DEV*DATA_W-1:0] dev_rdata
);

    window_t win [N_REGION];
    paddr_t  hole_base, rcl_base, rcl_lim;
    route_t  route_d, route_q;

    logic              busy_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rsp_valid_q, rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    logic              accept, done;
    logic [N_DEV-1:0]  dev_ack;
    logic [DATA_W-1:0] tgt_rdata;

    parr_cfg #(.N_REGION(N_REGION), .SEL_W(SEL_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we && !busy_q),
        .wr_sel    (cfg_sel),
        .wr_data   (cfg_wdata),
        .win       (win),
        .hole_base (hole_base),
        .rcl_base  (rcl_base),
        .rcl_lim   (rcl_lim)
    );

    parr_decode #(.N_REGION(N_REGION), .N_DEV(N_DEV)) u_dec (
        .addr      (req_addr),
        .win       (win),
        .hole_base (hole_base),
        .rcl_base  (rcl_base),
        .rcl_lim   (rcl_lim),
        .route     (route_d)
    );

    assign accept    = req_valid && !busy_q;
    assign req_ready = !busy_q;

    assign ram_valid = busy_q && (route_q.kind == DST_RAM);
    assign ram_addr  = route_q.addr;
    assign ram_we    = we_q;
    assign ram_wdata = wdata_q;

    for (genvar j = 0; j < N_DEV; j++) begin : g_dev
        assign dev_valid[j] = busy_q && (route_q.kind == DST_DEV)
                              && (route_q.dev == DEVIDX_W'(j));
        assign dev_ack[j]   = dev_valid[j] && dev_ready[j];
    end

    assign dev_addr  = route_q.addr;
    assign dev_we    = we_q;
    assign dev_wdata = wdata_q;

    always_comb begin
        tgt_rdata = ram_rdata;
        for (int j = 0; j < N_DEV; j++) begin
            if (dev_valid[j]) tgt_rdata = dev_rdata[j*DATA_W +: DATA_W];
        end
    end

    assign done = busy_q && ((route_q.kind == DST_NONE)
                             || (ram_valid && ram_ready)
                             || (|dev_ack));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            route_q     <= '{kind: DST_RAM, dev: '0, addr: '0};
            we_q        <= 1'b0;
            wdata_q     <= '0;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                route_q <= route_d;
                we_q    <= req_we;
                wdata_q <= req_wdata;
            end else if (done) begin
                busy_q      <= 1'b0;
                rsp_valid_q <= 1'b1;
                rsp_err_q   <= (route_q.kind == DST_NONE);
                rsp_rdata_q <= (route_q.kind == DST_NONE) ? '1 : tgt_rdata;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_err   = rsp_err_q;
    assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/parr_checker.sv
module parr_checker #(
    parameter int N_DEV  = 3,
    parameter int DATA_W = 32,
    parameter int PA_W   = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              ram_valid,
    input logic              ram_ready,
    input logic [PA_W-1:0]   ram_addr,
    input logic              ram_we,
    input logic [DATA_W-1:0] ram_wdata,
    input logic [DATA_W-1:0] ram_rdata,
    input logic [N_DEV-1:0]  dev_valid,
    input logic [N_DEV-1:0]  dev_ready,
    input logic [PA_W-1:0]   dev_addr,
    input logic              dev_we
);

    p_one_target_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_valid, dev_valid}));

    p_no_take_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (ram_valid || (|dev_valid)) |-> !req_ready);

    p_take_then_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_ram_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ram_valid && !ram_ready) |=>
            (ram_valid && $stable(ram_addr) && $stable(ram_we) && $stable(ram_wdata)));

    p_dev_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (|(dev_valid & ~dev_ready)) |=>
            ($stable(dev_valid) && $stable(dev_addr) && $stable(dev_we)));

    p_ram_reply_r9: assert property (@(posedge clk) disable iff (rst)
        (ram_valid && ram_ready) |=>
            (rsp_valid && !rsp_err && rsp_rdata == $past(ram_rdata)));

    p_err_untouched_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |->
            (!$past(ram_valid) && $past(dev_valid) == '0 && rsp_rdata == '1));

endmodule

bind phys_region_router parr_checker #(
    .N_DEV(N_DEV), .DATA_W(DATA_W), .PA_W(parr_pkg::PA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .ram_valid (ram_valid),
    .ram_ready (ram_ready),
    .ram_addr  (ram_addr),
    .ram_we    (ram_we),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .dev_valid (dev_valid),
    .dev_ready (dev_ready),
    .dev_addr  (dev_addr),
    .dev_we    (dev_we)
);

// File: tb/sim_phys_region_router.sv
`timescale 1ns/1ps
module sim_phys_region_router;

    localparam int NR = 4;
    localparam int ND = 3;
    localparam int DW = 32;
    localparam int SW = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [35:0]       req_addr = '0;
    logic              req_we = 1'b0;
    logic [DW-1:0]     req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [DW-1:0]     rsp_rdata;
    logic              cfg_we = 1'b0;
    logic [SW-1:0]     cfg_sel = '0;
    logic [35:0]       cfg_wdata = '0;
    logic              ram_valid;
    logic              ram_ready = 1'b0;
    logic [35:0]       ram_addr;
    logic              ram_we;
    logic [DW-1:0]     ram_wdata;
    logic [DW-1:0]     ram_rdata = '0;
    logic [ND-1:0]     dev_valid;
    logic [ND-1:0]     dev_ready = '0;
    logic [35:0]       dev_addr;
    logic              dev_we;
    logic [DW-1:0]     dev_wdata;
    logic [ND*DW-1:0]  dev_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference map kept by the bench
    logic [35:0] m_base [NR];
    logic [35:0] m_lim  [NR];
    bit          m_en   [NR];
    int          m_dev  [NR];
    logic [35:0] m_hole = 36'h0_C000_0000;
    logic [35:0] m_rb   = '1;
    logic [35:0] m_rl   = '0;

    always #2.5 clk = ~clk;

    phys_region_router #(.N_REGION(NR), .N_DEV(ND), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ram_valid(ram_valid), .ram_ready(ram_ready), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_addr(dev_addr),
        .dev_we(dev_we), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // kind: 0 RAM, 1 device, 2 error
    function automatic void model(input logic [35:0] a, output int kind,
                                  output int dv, output logic [35:0] ta);
        bit f = 1'b0;
        kind = 0; dv = 0; ta = a;
        for (int i = 0; i < NR; i++) begin
            if (!f && m_en[i] && a >= m_base[i] && a <= m_lim[i]) begin
                f = 1'b1;
                if (m_dev[i] < ND) begin kind = 1; dv = m_dev[i]; end
                else kind = 2;
            end
        end
        if (!f) begin
            if (a >= 36'h0A0000 && a <= 36'h0FFFFF) kind = 2;
            else if (a >= m_hole && a <= 36'h0_FFFF_FFFF) kind = 2;
            else if (a >= m_rb && a <= m_rl) ta = a - m_rb + m_hole;
        end
    endfunction

    task automatic cfg(input int sel, input logic [35:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) m_hole = d;
        else if (sel == 1) m_rb = d;
        else if (sel == 2) m_rl = d;
        else if (sel >= 4) begin
            case (sel % 4)
                0: m_base[sel/4-1] = d;
                1: m_lim[sel/4-1]  = d;
                2: begin m_en[sel/4-1] = d[0]; m_dev[sel/4-1] = int'(d[4:1]); end
                default: ;
            endcase
        end
    endtask

    task automatic set_win(input int i, input logic [35:0] b, input logic [35:0] l,
                           input bit en, input int dv);
        cfg(4*(i+1), b);
        cfg(4*(i+1)+1, l);
        cfg(4*(i+1)+2, 36'((dv << 1) | int'(en)));
    endtask

    task automatic access(input logic [35:0] a, input bit we, input int dly,
                          input string rq, input bit inj, input int isel,
                          input logic [35:0] idata);
        int kind, dv;
        logic [35:0] ta;
        logic [DW-1:0] rd, wd;
        model(a, kind, dv, ta);
        wd = a[31:0] ^ 32'h1234_5678;
        @(negedge clk);
        chk(req_ready, {rq, " R8 ready when idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_addr = '0;
        if (kind == 2) begin
            chk(!ram_valid && dev_valid == '0, {rq, " R7 error raises no target"},
                64'({ram_valid, dev_valid}), 64'd0);
            @(negedge clk);
            chk(rsp_valid && rsp_err && rsp_rdata == '1, {rq, " R7 error response"},
                {31'd0, rsp_valid, rsp_err, rsp_rdata}, {31'd0, 2'b11, 32'hFFFF_FFFF});
        end else begin
            rd = a[31:0] ^ ((kind == 0) ? 32'hA5A5_0000 : (32'h0F0F_0000 + 32'(dv)));
            for (int c = 0; c <= dly; c++) begin
                if (inj && c == 0) begin
                    cfg_we = 1'b1; cfg_sel = SW'(isel); cfg_wdata = idata;
                end else begin
                    cfg_we = 1'b0;
                end
                if (kind == 0)
                    chk(ram_valid && dev_valid == '0 && ram_addr == ta && ram_we == we
                        && (!we || ram_wdata == wd) && !req_ready,
                        {rq, " RAM route"}, {25'd0, ram_valid, dev_valid, ram_addr},
                        {25'd0, 1'b1, 3'b000, ta});
                else
                    chk(!ram_valid && dev_valid == ND'(1 << dv) && dev_addr == a
                        && dev_we == we && (!we || dev_wdata == wd) && !req_ready,
                        {rq, " device route"}, {25'd0, ram_valid, dev_valid, dev_addr},
                        {25'd0, 1'b0, 3'(1 << dv), a});
                if (c < dly) @(negedge clk);
            end
            cfg_we = 1'b0;
            if (kind == 0) begin ram_ready = 1'b1; ram_rdata = rd; end
            else begin dev_ready[dv] = 1'b1; dev_rdata[dv*DW +: DW] = rd; end
            @(negedge clk);
            ram_ready = 1'b0; dev_ready = '0;
            chk(rsp_valid && !rsp_err && rsp_rdata == rd, {rq, " R9 completion data"},
                {31'd0, rsp_valid, rsp_err, rsp_rdata}, {31'd0, 2'b10, rd});
        end
    endtask

    task automatic acc(input logic [35:0] a, input bit we, input int dly, input string rq);
        access(a, we, dly, rq, 1'b0, 0, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [35:0] keys [12];
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_en[i] = 1'b0; m_dev[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !ram_valid && dev_valid == '0 && !rsp_valid, "R1 idle after reset",
            64'({req_ready, ram_valid, dev_valid, rsp_valid}), 64'b100000);

        // default map
        acc(36'h0_0000_0000, 1'b0, 0, "R2 low RAM");
        acc(36'h0_0009_FFFF, 1'b1, 1, "R2 below legacy");
        acc(36'h0_000A_0000, 1'b0, 0, "R4 legacy start");
        acc(36'h0_000F_FFFF, 1'b1, 0, "R4 legacy end");
        acc(36'h0_0010_0000, 1'b0, 2, "R2 above legacy");
        acc(36'h0_BFFF_FFFF, 1'b0, 0, "R2 under hole");
        acc(36'h0_C000_0000, 1'b0, 0, "R1 R5 reset hole base");
        acc(36'h0_FFFF_FFFF, 1'b0, 0, "R5 hole top");
        acc(36'h1_0000_0000, 1'b0, 0, "R1 R6 reclaim empty");

        // programmed map
        cfg(0, 36'h0_E000_0000);
        set_win(0, 36'h0_E000_0000, 36'h0_E0FF_FFFF, 1'b1, 1);
        set_win(1, 36'h0_E000_0000, 36'h0_EFFF_FFFF, 1'b1, 2);
        set_win(2, 36'h0_000A_0000, 36'h0_000B_FFFF, 1'b1, 0);
        set_win(3, 36'h0_F000_0000, 36'h0_F000_0FFF, 1'b1, 5);
        cfg(1, 36'h1_0000_0000);
        cfg(2, 36'h1_1FFF_FFFF);

        acc(36'h0_E000_0000, 1'b0, 1, "R3 lowest window wins");
        acc(36'h0_E100_0000, 1'b1, 0, "R3 second window");
        acc(36'h0_000A_0000, 1'b0, 0, "R4 claimed legacy");
        acc(36'h0_000C_0000, 1'b0, 0, "R4 unclaimed legacy");
        acc(36'h0_F000_0000, 1'b0, 0, "R11 bad device index");
        acc(36'h0_F000_1000, 1'b1, 0, "R5 R7 unowned hole write");
        acc(36'h0_DFFF_FFFF, 1'b0, 0, "R2 R11 moved hole base");
        acc(36'h1_0000_0010, 1'b0, 1, "R6 reclaim low");
        acc(36'h1_1FFF_FFFF, 1'b1, 0, "R6 reclaim top");
        acc(36'h1_2000_0000, 1'b0, 0, "R2 past reclaim");

        // R10: a write while busy is dropped
        access(36'h0_2000_0000, 1'b0, 3, "R10 busy during write", 1'b1, 4, 36'h0);
        acc(36'h0_0000_1000, 1'b0, 0, "R10 dropped write left map");

        // R11: disabling window 0 exposes window 1
        cfg(6, 36'h0);
        acc(36'h0_E000_0000, 1'b0, 0, "R11 disabled window skipped");

        // boundary sweep
        keys[0] = 36'h0_000A_0000; keys[1] = 36'h0_000C_0000; keys[2] = 36'h0_0010_0000;
        keys[3] = m_hole;          keys[4] = 36'h0_E100_0000; keys[5] = 36'h0_F000_0000;
        keys[6] = 36'h0_F000_1000; keys[7] = 36'h1_0000_0000; keys[8] = m_rl + 1;
        keys[9] = 36'h0_F000_0800; keys[10] = 36'h0_EFFF_FFFF + 1; keys[11] = 36'h0_0000_0001;
        for (int k = 0; k < 12; k++) begin
            acc(keys[k] - 1, k[0], k % 3, "R2 R3 R4 R5 R6 boundary below");
            acc(keys[k],     !k[0], (k + 1) % 3, "R2 R3 R4 R5 R6 boundary at");
        end
        for (int s = 0; s < 40; s++) begin
            acc(36'(s) * 36'h0_0800_0000 + 36'(s * 4), s[0], s % 3, "R2 R5 R6 stride sweep");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule